// File: doc/BRIEF.md
# Banked Stack Pointer Unit

This unit manages the stack pointers of a small processor core. It keeps two banked pointers, a main pointer and a process pointer. The active one is chosen from the core's mode input and a select bit that software can write. Exception handlers always run on the main pointer. In thread mode the process pointer is used only while the select bit is set. The stack is full-descending. A push lowers the active pointer by one word and writes at the new address. A pop reads at the current address and then raises the pointer. Both drive a word-wide memory port whose read data returns in the same cycle.

On exception entry the unit runs a sequence that saves eight context words onto the stack that is active at that moment. It takes each word from the core through an indexed read port. On exception return it reads the frame back from the stack named by the core and delivers each word through an indexed write port. Each pointer has its own limit register. A push or frame that would take the pointer below its limit is refused, and a sticky overflow flag is raised instead. At reset the main pointer is loaded from the boot value supplied by the core.

Top module: `sp_bank_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sp_main` equals `boot_sp` with its two low bits cleared. `sp_proc` is 0, `use_proc` is 0, `busy` is 0 and `ovf` is 0.
- R2: An accepted push drives `mem_req`=1, `mem_we`=1, `mem_addr` = active pointer − 4 and `mem_wdata` = `push_data` in the same cycle. From the next cycle the active pointer equals that address.
- R3: An accepted pop drives `mem_req`=1, `mem_we`=0 and `mem_addr` = active pointer in the same cycle, with the popped word on `mem_rdata`. From the next cycle the active pointer is 4 higher.
- R4: `use_proc` equals (not `handler_mode`) and the select bit. When `handler_mode`=1, pushes and pops always act on the main pointer.
- R5: A select write (`sel_we`) in thread mode sets the select bit to `sel_val` from the next cycle. A select write while `handler_mode`=1 leaves the select bit unchanged.
- R6: An accepted `exc_entry` starts eight write cycles, beginning the next cycle, with `busy`=1 in exactly those cycles. In cycle j (0..7) the unit writes context word 7−j, fetched with `ctx_idx`=7−j, to P−4(j+1), where P is the active pointer at entry. The word indices are 0=R0, 1=R1, 2=R2, 3=R3, 4=R12, 5=LR, 6=PC and 7=status. The status word therefore lands highest and R0 lowest, and the pointer ends at P−32.
- R7: An `exc_return` starts eight read cycles, beginning the next cycle, on the process pointer if `ret_proc`=1 and otherwise on the main pointer. In cycle j it reads at Q+4j, where Q is that pointer at the start, and drives `ctx_we`=1, `ctx_idx`=j and `ctx_wdata`=`mem_rdata`. The pointer ends at Q+32.
- R8: A push is refused when active pointer − 4 is below the active limit. An entry is refused when active pointer − 32 is below it. A refused request makes no memory access, leaves both pointers unchanged and sets `ovf` from the next cycle.
- R9: `ovf` stays set until a cycle with `ovf_clr`=1. When a new overflow and `ovf_clr` occur in the same cycle, the flag stays set.
- R10: Pointer writes (`sp_we`) and limit writes (`lim_we`) store their value with the two low bits forced to zero. `sp_which`/`lim_which` select main (0) or process (1).
- R11: While `busy`=1, push, pop, entry, return and pointer-write requests are ignored. When idle, priority runs entry, then return, then push, then pop. A pointer write takes effect only in a cycle with none of those four requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_sp | input | AW (32) | Initial main pointer value captured during reset |
| handler_mode | input | 1 | 1 while the core runs an exception handler |
| sel_we | input | 1 | Write strobe for the select bit |
| sel_val | input | 1 | New select bit value |
| sp_we | input | 1 | Pointer write strobe |
| sp_which | input | 1 | Pointer write target: 0 main, 1 process |
| sp_wval | input | AW (32) | Pointer write value |
| lim_we | input | 1 | Limit write strobe |
| lim_which | input | 1 | Limit write target: 0 main, 1 process |
| lim_wval | input | AW (32) | Limit write value |
| push_req | input | 1 | Push one word |
| push_data | input | DW (32) | Word to push |
| pop_req | input | 1 | Pop one word |
| exc_entry | input | 1 | Start context saving |
| exc_return | input | 1 | Start context restoring |
| ret_proc | input | 1 | Return frame lies on the process stack |
| ctx_rdata | input | DW (32) | Context word selected by `ctx_idx` during saving |
| ovf_clr | input | 1 | Clears the overflow flag |
| mem_rdata | input | DW (32) | Memory read data, same cycle as the address |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW (32) | Byte address of the access |
| mem_wdata | output | DW (32) | Memory write data |
| ctx_idx | output | IDXW (3) | Context word index for saving or restoring |
| ctx_we | output | 1 | Restored context word valid |
| ctx_wdata | output | DW (32) | Restored context word |
| sp_main | output | AW (32) | Main pointer |
| sp_proc | output | AW (32) | Process pointer |
| use_proc | output | 1 | Process pointer is active |
| busy | output | 1 | Saving or restoring in progress |
| ovf | output | 1 | Sticky overflow flag |

## Verification
Results fall into three timing classes. The memory port of a push or pop, and `use_proc` after a mode change, are combinational in the cycle the request is driven. The pointer, select-bit and overflow updates appear one cycle later. Saving and restoring occupy cycles 1 to 8 after the entry or return pulse, and `busy` drops in cycle 9. The bench drives each request just after a falling edge and reads same-cycle outputs shortly after that. It reads registered results at the following falling edge and walks the eight sequence cycles one falling edge at a time, comparing address, index and data against values computed from the entry pointer.

// File: rtl/spbu_pkg.sv
package spbu_pkg;

   typedef enum logic [1:0] {
      PTR_HOLD,
      PTR_DEC,
      PTR_INC,
      PTR_LOAD
   } ptr_op_e;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_SAVE,
      SEQ_RESTORE
   } seq_state_e;

   localparam int unsigned NUM_BANKS = 2;
   localparam int unsigned BANK_MAIN = 0;
   localparam int unsigned BANK_PROC = 1;

endpackage

// File: rtl/spbu_bank.sv
module spbu_bank
   import spbu_pkg::*;
#(
   parameter int unsigned AW    = 32,
   parameter int unsigned ALIGN = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rst_ptr,
   input  ptr_op_e       op,
   input  logic [AW-1:0] load_val,
   input  logic          lim_we,
   input  logic [AW-1:0] lim_val,
   output logic [AW-1:0] ptr,
   output logic [AW-1:0] lim
);
   localparam int unsigned UW = AW - ALIGN;

   logic [UW-1:0] ptr_q;
   logic [UW-1:0] lim_q;

   initial begin
      if (AW <= ALIGN + 1) $error("spbu_bank: AW too small for ALIGN");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= UW'(rst_ptr >> ALIGN);
      end else begin
         unique case (op)
            PTR_DEC:  ptr_q <= ptr_q - UW'(1);
            PTR_INC:  ptr_q <= ptr_q + UW'(1);
            PTR_LOAD: ptr_q <= UW'(load_val >> ALIGN);
            default:  ptr_q <= ptr_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_q <= '0;
      end else if (lim_we) begin
         lim_q <= UW'(lim_val >> ALIGN);
      end
   end

   assign ptr = {ptr_q, {ALIGN{1'b0}}};
   assign lim = {lim_q, {ALIGN{1'b0}}};

endmodule

// File: rtl/spbu_limit.sv
module spbu_limit #(
   parameter int unsigned AW          = 32,
   parameter int unsigned STEP        = 4,
   parameter int unsigned FRAME_BYTES = 32,
   parameter bit          LIMIT_CHECK = 1'b1
) (
   input  logic [AW-1:0] ptr,
   input  logic [AW-1:0] lim,
   output logic          push_ok,
   output logic          frame_ok
);
   generate
      if (LIMIT_CHECK) begin : g_check
         logic [AW:0] ptr_x;
         logic [AW:0] need_push;
         logic [AW:0] need_frame;
         assign ptr_x      = {1'b0, ptr};
         assign need_push  = {1'b0, lim} + (AW+1)'(STEP);
         assign need_frame = {1'b0, lim} + (AW+1)'(FRAME_BYTES);
         assign push_ok    = ptr_x >= need_push;
         assign frame_ok   = ptr_x >= need_frame;
      end else begin : g_nocheck
         assign push_ok  = 1'b1;
         assign frame_ok = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/spbu_seq.sv
module spbu_seq
   import spbu_pkg::*;
#(
   parameter  int unsigned CTX_WORDS = 8,
   localparam int unsigned IDXW      = $clog2(CTX_WORDS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_save,
   input  logic            start_restore,
   input  logic            bank_sel,
   output seq_state_e      state,
   output logic            bank_q,
   output logic [IDXW-1:0] word_idx
);
   logic [IDXW-1:0] cnt_q;
   logic            last;

   assign last = (cnt_q == IDXW'(CTX_WORDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SEQ_IDLE;
         cnt_q  <= '0;
         bank_q <= 1'b0;
      end else begin
         unique case (state)
            SEQ_IDLE: begin
               cnt_q <= '0;
               if (start_save) begin
                  state  <= SEQ_SAVE;
                  bank_q <= bank_sel;
               end else if (start_restore) begin
                  state  <= SEQ_RESTORE;
                  bank_q <= bank_sel;
               end
            end
            default: begin
               if (last) begin
                  state <= SEQ_IDLE;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + IDXW'(1);
               end
            end
         endcase
      end
   end

   assign word_idx = (state == SEQ_SAVE) ? (IDXW'(CTX_WORDS - 1) - cnt_q) : cnt_q;

endmodule

// File: rtl/sp_bank_unit.sv
module sp_bank_unit
   import spbu_pkg::*;
#(
   parameter  int unsigned AW          = 32,
   parameter  int unsigned DW          = 32,
   parameter  int unsigned ALIGN       = 2,
   parameter  int unsigned CTX_WORDS   = 8,
   parameter  bit          LIMIT_CHECK = 1'b1,
   localparam int unsigned IDXW        = $clog2(CTX_WORDS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   boot_sp,
   input  logic            handler_mode,
   input  logic            sel_we,
   input  logic            sel_val,
   input  logic            sp_we,
   input  logic            sp_which,
   input  logic [AW-1:0]   sp_wval,
   input  logic            lim_we,
   input  logic            lim_which,
   input  logic [AW-1:0]   lim_wval,
   input  logic            push_req,
   input  logic [DW-1:0]   push_data,
   input  logic            pop_req,
   input  logic            exc_entry,
   input  logic            exc_return,
   input  logic            ret_proc,
   input  logic [DW-1:0]   ctx_rdata,
   input  logic            ovf_clr,
   input  logic [DW-1:0]   mem_rdata,
   output logic            mem_req,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_wdata,
   output logic [IDXW-1:0] ctx_idx,
   output logic            ctx_we,
   output logic [DW-1:0]   ctx_wdata,
   output logic [AW-1:0]   sp_main,
   output logic [AW-1:0]   sp_proc,
   output logic            use_proc,
   output logic            busy,
   output logic            ovf
);
   localparam int unsigned STEP        = 1 << ALIGN;
   localparam int unsigned FRAME_BYTES = CTX_WORDS * STEP;

   initial begin
      if (CTX_WORDS < 2) $error("sp_bank_unit: CTX_WORDS must be at least 2");
      if (DW != 8 * STEP) $error("sp_bank_unit: DW must match the word step");
      if (AW <= ALIGN + IDXW) $error("sp_bank_unit: AW too small");
   end

   // select bit
   logic sel_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       sel_q <= 1'b0;
      else if (sel_we && !handler_mode) sel_q <= sel_val;
   end
   assign use_proc = !handler_mode && sel_q;

   // pointer banks
   ptr_op_e       bank_op  [NUM_BANKS];
   logic [AW-1:0] bank_ptr [NUM_BANKS];
   logic [AW-1:0] bank_lim [NUM_BANKS];

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         spbu_bank #(.AW(AW), .ALIGN(ALIGN)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .rst_ptr  ((b == BANK_MAIN) ? boot_sp : {AW{1'b0}}),
            .op       (bank_op[b]),
            .load_val (sp_wval),
            .lim_we   (lim_we && (lim_which == 1'(b))),
            .lim_val  (lim_wval),
            .ptr      (bank_ptr[b]),
            .lim      (bank_lim[b])
         );
      end
   endgenerate

   assign sp_main = bank_ptr[BANK_MAIN];
   assign sp_proc = bank_ptr[BANK_PROC];

   logic [AW-1:0] act_sp;
   logic [AW-1:0] act_lim;
   assign act_sp  = bank_ptr[use_proc];
   assign act_lim = bank_lim[use_proc];

   // limit comparison
   logic push_ok;
   logic frame_ok;
   spbu_limit #(
      .AW(AW), .STEP(STEP), .FRAME_BYTES(FRAME_BYTES), .LIMIT_CHECK(LIMIT_CHECK)
   ) u_limit (
      .ptr      (act_sp),
      .lim      (act_lim),
      .push_ok  (push_ok),
      .frame_ok (frame_ok)
   );

   // request arbitration
   logic idle, take_entry, take_ret, take_push, take_pop;
   logic save_go, push_go, ovf_set, ptr_wr_go, any_req;

   assign idle       = !busy;
   assign take_entry = idle && exc_entry;
   assign take_ret   = idle && !exc_entry && exc_return;
   assign take_push  = idle && !exc_entry && !exc_return && push_req;
   assign take_pop   = idle && !exc_entry && !exc_return && !push_req && pop_req;
   assign save_go    = take_entry && frame_ok;
   assign push_go    = take_push && push_ok;
   assign ovf_set    = (take_entry && !frame_ok) || (take_push && !push_ok);
   assign any_req    = exc_entry || exc_return || push_req || pop_req;
   assign ptr_wr_go  = idle && sp_we && !any_req;

   // context sequencer
   seq_state_e      seq_state;
   logic            seq_bank;
   logic [IDXW-1:0] seq_idx;

   spbu_seq #(.CTX_WORDS(CTX_WORDS)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_save    (save_go),
      .start_restore (take_ret),
      .bank_sel      (take_ret ? ret_proc : use_proc),
      .state         (seq_state),
      .bank_q        (seq_bank),
      .word_idx      (seq_idx)
   );

   logic saving, restoring;
   assign saving    = (seq_state == SEQ_SAVE);
   assign restoring = (seq_state == SEQ_RESTORE);
   assign busy      = saving || restoring;

   // per-bank pointer operation
   always_comb begin
      for (int b = 0; b < NUM_BANKS; b++) begin
         bank_op[b] = PTR_HOLD;
         if (busy) begin
            if (seq_bank == 1'(b)) bank_op[b] = saving ? PTR_DEC : PTR_INC;
         end else if (push_go && (use_proc == 1'(b))) begin
            bank_op[b] = PTR_DEC;
         end else if (take_pop && (use_proc == 1'(b))) begin
            bank_op[b] = PTR_INC;
         end else if (ptr_wr_go && (sp_which == 1'(b))) begin
            bank_op[b] = PTR_LOAD;
         end
      end
   end

   // memory port
   logic [AW-1:0] seq_sp;
   assign seq_sp = bank_ptr[seq_bank];

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      if (saving) begin
         mem_req   = 1'b1;
         mem_we    = 1'b1;
         mem_addr  = seq_sp - AW'(STEP);
         mem_wdata = ctx_rdata;
      end else if (restoring) begin
         mem_req   = 1'b1;
         mem_addr  = seq_sp;
      end else if (push_go) begin
         mem_req   = 1'b1;
         mem_we    = 1'b1;
         mem_addr  = act_sp - AW'(STEP);
         mem_wdata = push_data;
      end else if (take_pop) begin
         mem_req   = 1'b1;
         mem_addr  = act_sp;
      end
   end

   assign ctx_idx   = seq_idx;
   assign ctx_we    = restoring;
   assign ctx_wdata = mem_rdata;

   // sticky overflow
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf <= 1'b0;
      else if (ovf_set) ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
   end

endmodule

// File: rtl/spbu_checker.sv
module spbu_checker #(
   parameter int unsigned AW        = 32,
   parameter int unsigned ALIGN     = 2,
   parameter int unsigned CTX_WORDS = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          handler_mode,
   input logic          push_req,
   input logic          exc_entry,
   input logic          exc_return,
   input logic          ovf_clr,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic          ctx_we,
   input logic [AW-1:0] sp_main,
   input logic [AW-1:0] sp_proc,
   input logic          use_proc,
   input logic          busy,
   input logic          ovf
);
   localparam int unsigned STEP = 1 << ALIGN;
   localparam int unsigned RW   = $clog2(CTX_WORDS + 2);

   logic [RW-1:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_q <= '0;
      else if (busy) run_q <= run_q + RW'(1);
      else           run_q <= '0;
   end

   AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && push_req && !exc_entry && !exc_return && mem_req && mem_we)
      |=> (($past(use_proc) ? sp_proc : sp_main) == $past(mem_addr))); // R2

   AST_POP_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && mem_req && !mem_we) |-> (mem_addr == (use_proc ? sp_proc : sp_main))); // R3

   AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && mem_req && !mem_we)
      |=> (($past(use_proc) ? sp_proc : sp_main) == $past(mem_addr) + AW'(STEP))); // R3

   AST_HANDLER_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
      handler_mode |-> !use_proc); // R4

   AST_SEQ_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(exc_entry || exc_return)); // R6

   AST_SEQ_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RW'(CTX_WORDS)); // R6

   AST_RESTORE_READS: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_we |-> (mem_req && !mem_we)); // R7

   AST_BLOCKED_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && push_req && !exc_entry && !exc_return && !mem_req)
      |=> (ovf && sp_main == $past(sp_main) && sp_proc == $past(sp_proc))); // R8

   AST_OVF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ovf_clr) |=> ovf); // R9

endmodule

bind sp_bank_unit spbu_checker #(
   .AW(AW), .ALIGN(ALIGN), .CTX_WORDS(CTX_WORDS)
) u_spbu_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .handler_mode (handler_mode),
   .push_req     (push_req),
   .exc_entry    (exc_entry),
   .exc_return   (exc_return),
   .ovf_clr      (ovf_clr),
   .mem_req      (mem_req),
   .mem_we       (mem_we),
   .mem_addr     (mem_addr),
   .ctx_we       (ctx_we),
   .sp_main      (sp_main),
   .sp_proc      (sp_proc),
   .use_proc     (use_proc),
   .busy         (busy),
   .ovf          (ovf)
);

// File: tb/sp_bank_unit_test.sv
module sp_bank_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] boot_sp;
   logic          handler_mode, sel_we, sel_val, sp_we, sp_which;
   logic [AW-1:0] sp_wval;
   logic          lim_we, lim_which;
   logic [AW-1:0] lim_wval;
   logic          push_req, pop_req, exc_entry, exc_return, ret_proc, ovf_clr;
   logic [DW-1:0] push_data, ctx_rdata, mem_rdata;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [2:0]    ctx_idx;
   logic          ctx_we;
   logic [DW-1:0] ctx_wdata;
   logic [AW-1:0] sp_main, sp_proc;
   logic          use_proc, busy, ovf;

   int n_chk = 0;
   int n_err = 0;

   logic [DW-1:0] mem [256];
   logic [DW-1:0] ref_mem [256];

   always #(CLK_PERIOD/2) clk = ~clk;

   sp_bank_unit uut (
      .clk(clk), .rst_n(rst_n), .boot_sp(boot_sp), .handler_mode(handler_mode),
      .sel_we(sel_we), .sel_val(sel_val), .sp_we(sp_we), .sp_which(sp_which),
      .sp_wval(sp_wval), .lim_we(lim_we), .lim_which(lim_which), .lim_wval(lim_wval),
      .push_req(push_req), .push_data(push_data), .pop_req(pop_req),
      .exc_entry(exc_entry), .exc_return(exc_return), .ret_proc(ret_proc),
      .ctx_rdata(ctx_rdata), .ovf_clr(ovf_clr), .mem_rdata(mem_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .ctx_idx(ctx_idx), .ctx_we(ctx_we), .ctx_wdata(ctx_wdata),
      .sp_main(sp_main), .sp_proc(sp_proc), .use_proc(use_proc),
      .busy(busy), .ovf(ovf)
   );

   // memory and context models
   assign mem_rdata = mem[mem_addr[9:2]];
   assign ctx_rdata = 32'hC0DE_0000 | {29'd0, ctx_idx};
   always @(posedge clk) begin
      if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
   end

   function automatic logic [31:0] ctx_word(input int k);
      return 32'hC0DE_0000 | k;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      sel_we = 0; sel_val = 0; sp_we = 0; sp_which = 0; sp_wval = '0;
      lim_we = 0; lim_which = 0; lim_wval = '0; push_req = 0; push_data = '0;
      pop_req = 0; exc_entry = 0; exc_return = 0; ret_proc = 0; ovf_clr = 0;
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   // one-cycle operations; inputs change only at falling edges
   task automatic do_push(input logic [31:0] d);
      @(negedge clk); push_req = 1; push_data = d;
      #1;
      @(negedge clk); push_req = 0;
   endtask

   task automatic write_ptr(input logic which, input logic [31:0] v);
      @(negedge clk); sp_we = 1; sp_which = which; sp_wval = v;
      @(negedge clk); sp_we = 0;
   endtask

   task automatic write_lim(input logic which, input logic [31:0] v);
      @(negedge clk); lim_we = 1; lim_which = which; lim_wval = v;
      @(negedge clk); lim_we = 0;
   endtask

   task automatic write_sel(input logic v);
      @(negedge clk); sel_we = 1; sel_val = v;
      @(negedge clk); sel_we = 0;
   endtask

   task automatic clear_ovf();
      @(negedge clk); ovf_clr = 1;
      @(negedge clk); ovf_clr = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog R1..R11 act=running exp=done");
      finish_run();
   end

   initial begin
      logic [31:0] m_sp [2];
      logic        m_sel;
      logic        m_ovf;
      int          depth [2];
      int          seed_dummy;

      idle_inputs();
      handler_mode = 0;
      boot_sp = 32'h0000_0402;
      rst_n = 0;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 main pointer in reset", sp_main, 32'h400);
      rst_n = 1;
      @(negedge clk); #1;
      chk("R1 main pointer from boot", sp_main, 32'h400);
      chk("R1 process pointer", sp_proc, 32'h0);
      chk("R1 use_proc", {31'd0, use_proc}, 32'd0);
      chk("R1 ovf", {31'd0, ovf}, 32'd0);
      chk("R1 busy", {31'd0, busy}, 32'd0);

      // R2 push
      @(negedge clk); push_req = 1; push_data = 32'h1111_1111;
      #1;
      chk("R2 push we", {31'd0, mem_we}, 32'd1);
      chk("R2 push addr", mem_addr, 32'h3FC);
      chk("R2 push data", mem_wdata, 32'h1111_1111);
      @(negedge clk); push_req = 0; #1;
      chk("R2 pointer after push", sp_main, 32'h3FC);
      do_push(32'h2222_2222);
      #1;
      chk("R2 second push", sp_main, 32'h3F8);

      // R3 pop
      @(negedge clk); pop_req = 1;
      #1;
      chk("R3 pop addr", mem_addr, 32'h3F8);
      chk("R3 pop data", mem_rdata, 32'h2222_2222);
      chk("R3 pop read", {31'd0, mem_we}, 32'd0);
      @(negedge clk); pop_req = 0; #1;
      chk("R3 pointer after pop", sp_main, 32'h3FC);

      // R11 push beats pop; pointer write blocked by a request
      @(negedge clk); push_req = 1; pop_req = 1; push_data = 32'h3333_3333;
      sp_we = 1; sp_which = 1; sp_wval = 32'h500;
      #1;
      chk("R11 push over pop", {31'd0, mem_we}, 32'd1);
      @(negedge clk); idle_inputs(); #1;
      chk("R11 push taken", sp_main, 32'h3F8);
      chk("R11 pointer write ignored", sp_proc, 32'h0);

      // R10 alignment of pointer writes
      write_ptr(1'b1, 32'h0000_1237);
      #1;
      chk("R10 pointer aligned", sp_proc, 32'h1234);
      write_ptr(1'b1, 32'h0000_0300);

      // R5 / R4 select
      write_sel(1'b1);
      #1;
      chk("R5 select in thread", {31'd0, use_proc}, 32'd1);
      @(negedge clk); handler_mode = 1; #1;
      chk("R4 handler uses main", {31'd0, use_proc}, 32'd0);
      write_sel(1'b0);
      @(negedge clk); handler_mode = 0; #1;
      chk("R5 select write ignored in handler", {31'd0, use_proc}, 32'd1);

      // R4 push acts on process pointer in thread with select set
      do_push(32'h5555_5555);
      #1;
      chk("R4 process pushed", sp_proc, 32'h2FC);
      chk("R4 main untouched", sp_main, 32'h3F8);

      // R6 context saving from process stack, with blocked requests (R11)
      @(negedge clk); exc_entry = 1;
      for (int j = 0; j < 8; j++) begin
         @(negedge clk);
         exc_entry = 0;
         if (j == 0) begin
            push_req = 1; push_data = 32'h0BAD_0BAD;
            sp_we = 1; sp_which = 0; sp_wval = 32'h100;
         end else begin
            idle_inputs();
         end
         #1;
         chk("R6 busy", {31'd0, busy}, 32'd1);
         chk("R6 save write", {31'd0, mem_we}, 32'd1);
         chk("R6 save addr", mem_addr, 32'h2FC - 4 * (j + 1));
         chk("R6 save index", {29'd0, ctx_idx}, 32'(7 - j));
         chk("R6 save data", mem_wdata, ctx_word(7 - j));
      end
      @(negedge clk); #1;
      chk("R6 busy ends", {31'd0, busy}, 32'd0);
      chk("R6 frame pointer", sp_proc, 32'h2DC);
      chk("R11 pointer write during busy", sp_main, 32'h3F8);
      chk("R6 status highest", mem[8'hBE], ctx_word(7));
      chk("R6 R0 lowest", mem[8'hB7], ctx_word(0));

      // handler pushes go to main
      @(negedge clk); handler_mode = 1;
      do_push(32'h6666_6666);
      #1;
      chk("R4 handler push on main", sp_main, 32'h3F4);
      chk("R4 handler keeps process", sp_proc, 32'h2DC);
      @(negedge clk); pop_req = 1; #1;
      chk("R3 handler pop data", mem_rdata, 32'h6666_6666);
      @(negedge clk); pop_req = 0;

      // R7 restore from process stack
      @(negedge clk); exc_return = 1; ret_proc = 1; handler_mode = 0;
      for (int j = 0; j < 8; j++) begin
         @(negedge clk);
         exc_return = 0; ret_proc = 0;
         #1;
         chk("R7 restore read", {31'd0, mem_we}, 32'd0);
         chk("R7 restore addr", mem_addr, 32'h2DC + 4 * j);
         chk("R7 ctx_we", {31'd0, ctx_we}, 32'd1);
         chk("R7 restore index", {29'd0, ctx_idx}, 32'(j));
         chk("R7 restore data", ctx_wdata, ctx_word(j));
      end
      @(negedge clk); #1;
      chk("R7 busy ends", {31'd0, busy}, 32'd0);
      chk("R7 pointer restored", sp_proc, 32'h2FC);

      // R8 / R10 limits
      write_lim(1'b1, 32'h0000_02FB);
      do_push(32'h7777_7777);
      #1;
      chk("R10 limit aligned, push fits", sp_proc, 32'h2F8);
      chk("R8 no overflow at limit", {31'd0, ovf}, 32'd0);
      @(negedge clk); push_req = 1; push_data = 32'h8888_8888;
      #1;
      chk("R8 refused push no access", {31'd0, mem_req}, 32'd0);
      @(negedge clk); push_req = 0; #1;
      chk("R8 pointer kept", sp_proc, 32'h2F8);
      chk("R8 ovf set", {31'd0, ovf}, 32'd1);
      @(negedge clk); #1;
      chk("R9 ovf held", {31'd0, ovf}, 32'd1);
      clear_ovf();
      #1;
      chk("R9 ovf cleared", {31'd0, ovf}, 32'd0);
      @(negedge clk); exc_entry = 1;
      @(negedge clk); exc_entry = 0; #1;
      chk("R8 refused entry not busy", {31'd0, busy}, 32'd0);
      chk("R8 refused entry ovf", {31'd0, ovf}, 32'd1);
      chk("R8 refused entry pointer", sp_proc, 32'h2F8);
      clear_ovf();
      @(negedge clk); push_req = 1; ovf_clr = 1;
      @(negedge clk); idle_inputs(); #1;
      chk("R9 set wins over clear", {31'd0, ovf}, 32'd1);

      // randomized push / pop / select traffic checked against a model
      write_sel(1'b0);
      write_ptr(1'b0, 32'h400);
      write_ptr(1'b1, 32'h200);
      write_lim(1'b0, 32'h380);
      write_lim(1'b1, 32'h1C0);
      clear_ovf();
      m_sp[0] = 32'h400; m_sp[1] = 32'h200; m_sel = 0; m_ovf = 0;
      depth[0] = 0; depth[1] = 0;
      seed_dummy = int'($urandom(32'h5EED_1234));
      for (int i = 0; i < 400; i++) begin
         int op;
         int a;
         logic [31:0] d;
         op = int'($urandom % 8);
         a  = int'(m_sel);
         d  = $urandom;
         @(negedge clk);
         if (op < 4) begin
            push_req = 1; push_data = d;
            #1;
            if (m_sp[a] >= 32'(m_sp[a] - 4) && (m_sp[a] - 4) >= ((a == 0) ? 32'h380 : 32'h1C0)) begin
               chk("R2 random push addr", mem_addr, m_sp[a] - 4);
               m_sp[a] = m_sp[a] - 4;
               ref_mem[m_sp[a][9:2]] = d;
               depth[a]++;
            end else begin
               chk("R8 random refused push", {31'd0, mem_req}, 32'd0);
               m_ovf = 1;
            end
         end else if (op < 6) begin
            if (depth[a] > 0) begin
               pop_req = 1;
               #1;
               chk("R3 random pop data", mem_rdata, ref_mem[m_sp[a][9:2]]);
               m_sp[a] = m_sp[a] + 4;
               depth[a]--;
            end
         end else if (op == 6) begin
            sel_we = 1; sel_val = !m_sel;
            m_sel = !m_sel;
         end else begin
            ovf_clr = 1;
            m_ovf = 0;
         end
         @(negedge clk); idle_inputs(); #1;
         chk("R2 random main pointer", sp_main, m_sp[0]);
         chk("R3 random process pointer", sp_proc, m_sp[1]);
         chk("R5 random select", {31'd0, use_proc}, {31'd0, m_sel});
         chk("R9 random ovf", {31'd0, ovf}, {31'd0, m_ovf});
      end

      finish_run();
   end

endmodule